// File: doc/BRIEF.md
# Physical memory type resolver

This block answers one question for a memory subsystem: given a physical address range, which cache memory type applies to it? It holds a small configuration state and returns an 8-bit type code on a single-cycle registered path. The state is a global control word (default type plus two enable bits), a table of 88 fixed-granule type entries covering the first megabyte, a parameterised set of variable base/mask range pairs, and an upper-memory boundary register. All of it is loaded through a plain register write port.

A request carries a start address and an end address. The end is exclusive, so the block matches the inclusive last byte `end - 1`. The first megabyte is served from the fixed table. Above it, every enabled variable range that covers the request contributes its type. The contributions are combined under precedence rules: uncacheable wins, and write-back combined with write-through gives write-through. A request that is only partly covered by a range gets a special "straddle" code. Two further codes exist: one for "no information" and one for a boundary-register rule that makes high memory write-back.

Top module: `memtype_resolver`

## Requirements
- R1: While no control word has been written since reset, or while both enable bits are 0, every lookup returns 0xFF.
- R2: A response is due on the clock edge after the edge that captures `req_valid`. `rsp_valid` is high for exactly that cycle, and `rsp_type` holds its value in cycles without a request. After reset `rsp_valid` is 0 and `rsp_type` is 0xFF.
- R3: If the fixed table is present and start < 0x100000, the result is fixed entry `start>>16` for start below 0x80000. For start below 0xC0000 it is entry `8+((start-0x80000)>>14)`. Otherwise it is entry `24+((start-0xC0000)>>12)`. This holds whatever the enable bit for the variable ranges is.
- R4: Outside the fixed region, if enable bit 1 (variable ranges on) is 0, the result is the default type.
- R5: A variable range whose mask word has bit 11 clear takes no part in the lookup.
- R6: If, for a participating range, exactly one of start and `end-1` satisfies `(addr & mask) == (base & mask)`, the result is 0xFE. Bits 11:0 of base and mask are ignored.
- R7: When two covering ranges disagree and either of them is 0 (uncacheable), the result is 0. Any disagreement other than the one in R8 also gives 0.
- R8: Type 6 (write-back) combined with type 4 (write-through) resolves to 4, and the lookup goes on with 4.
- R9: If the boundary register is nonzero, start >= 2^32 and `end-1` < boundary, and no range settled the result with 0xFE or 0, the result is 6.
- R10: If no participating range covers the request and R9 does not apply, the result is the default type.
- R11: The end address is exclusive. A request ending exactly at the top of a range counts as inside that range.
- R12: A configuration write is seen by any request made in a later cycle. Writing the control word marks the configuration as loaded. Select map:
  - 0 is control: [7:0] default type, [9:8] enable bits.
  - 1 is the boundary register.
  - 2..12 are fixed words: byte j of word k is entry 8k+j.
  - 16+2i is the base of range i: [7:0] type, [51:12] base.
  - 17+2i is the mask of range i: [11] valid, [51:12] mask.
- R13: Ranges are taken in ascending index order, and the first range that settles the result with 0xFE or 0 decides it. A straddle at a higher index does not override an uncacheable result already reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W (5) | Configuration register select |
| cfg_wdata | input | 64 | Configuration write data |
| req_valid | input | 1 | Lookup request strobe |
| req_start | input | ADDR_W (52) | Range start address |
| req_end | input | ADDR_W (52) | Range end address (exclusive) |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_type | output | 8 | Resolved memory type |

## Verification
Every lookup result is due exactly one clock edge after its request is captured. The bench drives the request on a falling edge and samples `rsp_valid` and `rsp_type` on the next falling edge, half a cycle after the capturing rising edge. An idle cycle follows some requests and is sampled to confirm that `rsp_valid` drops and `rsp_type` holds. Configuration writes are driven one full cycle before the request that depends on them. The expected result is therefore always computed from the configuration as it stands after all prior writes.

// File: rtl/memtype_pkg.sv
// Package: shared constants for the memory type resolver.
// Assumes the select map and type codes below are fixed across the block.
package memtype_pkg;
    localparam logic [7:0] MT_UC    = 8'h00;
    localparam logic [7:0] MT_WT    = 8'h04;
    localparam logic [7:0] MT_WB    = 8'h06;
    localparam logic [7:0] MT_SPLIT = 8'hFE;
    localparam logic [7:0] MT_NONE  = 8'hFF;

    localparam int FIX_WORDS   = 11;
    localparam int FIX_ENTRIES = FIX_WORDS * 8;

    localparam int SEL_CTRL = 0;
    localparam int SEL_TOP  = 1;
    localparam int SEL_FIX0 = 2;
    localparam int SEL_VAR0 = 16;
endpackage

// File: rtl/mt_cfg_regs.sv
// Module: configuration storage for the resolver.
// Holds control, boundary, fixed table and variable range registers.
// Assumes ADDR_W lies between 33 and 64; writes land on the clock edge.
module mt_cfg_regs
    import memtype_pkg::*;
#(
    parameter int ADDR_W  = 52,
    parameter int NUM_VAR = 8,
    parameter int SEL_W   = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [SEL_W-1:0]                 sel,
    input  logic [63:0]                      wdata,
    output logic                             loaded,
    output logic [1:0]                       en,
    output logic [7:0]                       def_type,
    output logic [ADDR_W-1:0]                top_bound,
    output logic [FIX_ENTRIES*8-1:0]         fix_tbl,
    output logic [NUM_VAR-1:0][ADDR_W-1:0]   var_base,
    output logic [NUM_VAR-1:0][ADDR_W-1:0]   var_mask,
    output logic [NUM_VAR-1:0][7:0]          var_type,
    output logic [NUM_VAR-1:0]               var_on
);
    localparam int PG_W = ADDR_W - 12;

    // Control word and loaded flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded   <= 1'b0;
            en       <= 2'b00;
            def_type <= 8'h00;
        end else if (we && sel == SEL_W'(SEL_CTRL)) begin
            loaded   <= 1'b1;
            en       <= wdata[9:8];
            def_type <= wdata[7:0];
        end
    end

    // Upper-memory boundary register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            top_bound <= '0;
        else if (we && sel == SEL_W'(SEL_TOP))
            top_bound <= wdata[ADDR_W-1:0];
    end

    // Fixed table, one 64-bit word per select.
    for (genvar k = 0; k < FIX_WORDS; k++) begin : g_fix
        always_ff @(posedge clk) begin
            if (!rst_n)
                fix_tbl[k*64 +: 64] <= '0;
            else if (we && sel == SEL_W'(SEL_FIX0 + k))
                fix_tbl[k*64 +: 64] <= wdata;
        end
    end

    // Variable range base and mask pairs, page bits only.
    for (genvar g = 0; g < NUM_VAR; g++) begin : g_var
        logic [PG_W-1:0] base_pg, mask_pg;

        // Base word: page-aligned base plus type byte.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_pg     <= '0;
                var_type[g] <= 8'h00;
            end else if (we && sel == SEL_W'(SEL_VAR0 + 2*g)) begin
                base_pg     <= wdata[ADDR_W-1:12];
                var_type[g] <= wdata[7:0];
            end
        end

        // Mask word: page-aligned mask plus participation bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_pg   <= '0;
                var_on[g] <= 1'b0;
            end else if (we && sel == SEL_W'(SEL_VAR0 + 2*g + 1)) begin
                mask_pg   <= wdata[ADDR_W-1:12];
                var_on[g] <= wdata[11];
            end
        end

        assign var_base[g] = {base_pg, 12'h000};
        assign var_mask[g] = {mask_pg, 12'h000};
    end

    // R12: once loaded, the flag stays set until reset.
    p_loaded_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |=> loaded);
endmodule

// File: rtl/mt_fixed_lookup.sv
// Module: fixed-table index decode for the first megabyte.
// Three granule sizes: 64 KiB, then 16 KiB, then 4 KiB.
// Assumes start is meaningful only when in_fixed is high.
module mt_fixed_lookup
    import memtype_pkg::*;
#(
    parameter int ADDR_W = 52
) (
    input  logic [ADDR_W-1:0]        start,
    input  logic [FIX_ENTRIES*8-1:0] fix_tbl,
    output logic                     in_fixed,
    output logic [7:0]               fix_type
);
    logic [6:0] idx;

    // Pick granule band and derive the table index.
    always_comb begin
        in_fixed = start < ADDR_W'(20'hFFFFF) + ADDR_W'(1);
        if (start < ADDR_W'(20'h80000))
            idx = {4'd0, start[18:16]};
        else if (start < ADDR_W'(20'hC0000))
            idx = 7'd8 + {3'd0, start[17:14]};
        else
            idx = 7'd24 + {1'b0, start[17:12]};
    end

    assign fix_type = fix_tbl[{idx, 3'b000} +: 8];

    // R3: an index inside the first megabyte never leaves the table.
    always_comb begin
        if (in_fixed)
            p_fix_index_r3: assert (int'(idx) < FIX_ENTRIES);
    end
endmodule

// File: rtl/mt_var_match.sv
// Module: base/mask comparison of one variable range.
// Reports separately whether start and last byte fall inside the range.
// Assumes base and mask already have their low 12 bits cleared.
module mt_var_match #(
    parameter int ADDR_W = 52
) (
    input  logic [ADDR_W-1:0] start,
    input  logic [ADDR_W-1:0] last,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    output logic              hit_s,
    output logic              hit_e
);
    logic [ADDR_W-1:0] ref_key;

    // Masked compare of both ends against the masked base.
    always_comb begin
        ref_key = base & mask;
        hit_s   = (start & mask) == ref_key;
        hit_e   = (last  & mask) == ref_key;
    end
endmodule

// File: rtl/memtype_resolver.sv
// Module: top of the memory type resolver.
// Decodes control and fixed table, folds variable ranges in index order,
// applies the boundary rule and registers the result for one cycle.
// Assumes ADDR_W > 32 and cfg_wdata covers the address width.
module memtype_resolver
    import memtype_pkg::*;
#(
    parameter int  ADDR_W    = 52,
    parameter int  NUM_VAR   = 8,
    parameter bit  HAS_FIXED = 1'b1,
    localparam int SEL_W     = $clog2(SEL_VAR0 + 2*NUM_VAR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [63:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    output logic              rsp_valid,
    output logic [7:0]        rsp_type
);
    logic                           loaded;
    logic [1:0]                     en;
    logic [7:0]                     def_type;
    logic [ADDR_W-1:0]              top_bound;
    logic [FIX_ENTRIES*8-1:0]       fix_tbl;
    logic [NUM_VAR-1:0][ADDR_W-1:0] var_base, var_mask;
    logic [NUM_VAR-1:0][7:0]        var_type;
    logic [NUM_VAR-1:0]             var_on;
    logic [NUM_VAR-1:0]             hit_s, hit_e;
    logic [ADDR_W-1:0]              last;
    logic                           in_fixed;
    logic [7:0]                     fix_type;
    logic [7:0]                     acc, early, nxt;
    logic                           stop;

    assign last = req_end - ADDR_W'(1);

    mt_cfg_regs #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR), .SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .loaded(loaded), .en(en), .def_type(def_type), .top_bound(top_bound),
        .fix_tbl(fix_tbl), .var_base(var_base), .var_mask(var_mask),
        .var_type(var_type), .var_on(var_on)
    );

    mt_fixed_lookup #(.ADDR_W(ADDR_W)) u_fix (
        .start(req_start), .fix_tbl(fix_tbl),
        .in_fixed(in_fixed), .fix_type(fix_type)
    );

    for (genvar g = 0; g < NUM_VAR; g++) begin : g_match
        mt_var_match #(.ADDR_W(ADDR_W)) u_match (
            .start(req_start), .last(last),
            .base(var_base[g]), .mask(var_mask[g]),
            .hit_s(hit_s[g]), .hit_e(hit_e[g])
        );
    end

    // Priority fold over ranges in ascending order; first settling range wins.
    always_comb begin
        logic [7:0] a2, c2;
        acc   = MT_NONE;
        early = MT_UC;
        stop  = 1'b0;
        for (int i = 0; i < NUM_VAR; i++) begin
            a2 = acc;
            c2 = var_type[i];
            if (!stop && var_on[i]) begin
                if (hit_s[i] != hit_e[i]) begin
                    early = MT_SPLIT;
                    stop  = 1'b1;
                end else if (hit_s[i]) begin
                    if (acc == MT_NONE) begin
                        acc = c2;
                    end else if (acc == MT_UC || c2 == MT_UC) begin
                        early = MT_UC;
                        stop  = 1'b1;
                    end else begin
                        if ((a2 == MT_WB && c2 == MT_WT) || (a2 == MT_WT && c2 == MT_WB)) begin
                            a2 = MT_WT;
                            c2 = MT_WT;
                        end
                        if (a2 != c2) begin
                            early = MT_UC;
                            stop  = 1'b1;
                        end else begin
                            acc = a2;
                        end
                    end
                end
            end
        end
    end

    // Final selection across the lookup stages.
    always_comb begin
        if (!loaded || en == 2'b00)
            nxt = MT_NONE;
        else if (HAS_FIXED && in_fixed)
            nxt = fix_type;
        else if (!en[1])
            nxt = def_type;
        else if (stop)
            nxt = early;
        else if (top_bound != '0 && req_start[ADDR_W-1:32] != '0 && last < top_bound)
            nxt = MT_WB;
        else if (acc != MT_NONE)
            nxt = acc;
        else
            nxt = def_type;
    end

    // Output register: valid follows the strobe, type holds between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_type  <= MT_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid)
                rsp_type <= nxt;
        end
    end

    // R2: a request yields a response exactly one cycle later.
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2: no request, no response, and the type holds.
    p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && $stable(rsp_type));
    // R1: unloaded or fully disabled configuration gives no information.
    p_unloaded_none_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (!loaded || en == 2'b00) |=> rsp_type == MT_NONE);
    // R4: variable ranges off outside the fixed region gives the default.
    p_var_off_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && loaded && en == 2'b01 && !(HAS_FIXED && in_fixed)
        |=> rsp_type == $past(def_type));
    // R6, R13: a straddle on the lowest range always decides the result.
    p_first_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && loaded && en[1] && !(HAS_FIXED && in_fixed)
        && var_on[0] && hit_s[0] != hit_e[0] |=> rsp_type == MT_SPLIT);
endmodule

// File: tb/memtype_resolver_tb_top.sv
module memtype_resolver_tb_top;
    localparam int AW = 52;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_sel = '0;
    logic [63:0]   cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_start = '0;
    logic [AW-1:0] req_end = '0;
    logic          rsp_valid;
    logic [7:0]    rsp_type;

    int n_chk = 0;
    int n_bad = 0;

    // Shadow of the configuration, decoded from the select map.
    logic          m_loaded = 1'b0;
    logic [1:0]    m_en = 2'b00;
    logic [7:0]    m_def = 8'h00;
    logic [AW-1:0] m_top = '0;
    logic [7:0]    m_fix [88];
    logic [AW-1:0] m_base [NV];
    logic [AW-1:0] m_mask [NV];
    logic [7:0]    m_type [NV];
    logic          m_on [NV];

    always #2 clk = ~clk;

    memtype_resolver #(.ADDR_W(AW), .NUM_VAR(NV)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_start(req_start),
        .req_end(req_end), .rsp_valid(rsp_valid), .rsp_type(rsp_type)
    );

    function automatic logic [7:0] ref_type(input logic [AW-1:0] s, input logic [AW-1:0] e);
        logic [AW-1:0] l;
        logic [7:0] prev, cur;
        logic ms, me;
        int idx;
        l = e - 1;
        if (!m_loaded || m_en == 2'b00) return 8'hFF;
        if (s < 52'h100000) begin
            if (s < 52'h80000) idx = int'(s >> 16);
            else if (s < 52'hC0000) idx = 8 + int'((s - 52'h80000) >> 14);
            else idx = 24 + int'((s - 52'hC0000) >> 12);
            return m_fix[idx];
        end
        if (!m_en[1]) return m_def;
        prev = 8'hFF;
        for (int i = 0; i < NV; i++) begin
            if (!m_on[i]) continue;
            ms = (s & m_mask[i]) == (m_base[i] & m_mask[i]);
            me = (l & m_mask[i]) == (m_base[i] & m_mask[i]);
            if (ms != me) return 8'hFE;
            if (!ms) continue;
            cur = m_type[i];
            if (prev == 8'hFF) begin prev = cur; continue; end
            if (prev == 8'h00 || cur == 8'h00) return 8'h00;
            if ((prev == 8'h06 && cur == 8'h04) || (prev == 8'h04 && cur == 8'h06)) begin
                prev = 8'h04; cur = 8'h04;
            end
            if (prev != cur) return 8'h00;
        end
        if (m_top != '0 && s >= 52'h1_0000_0000 && l < m_top) return 8'h06;
        if (prev != 8'hFF) return prev;
        return m_def;
    endfunction

    task automatic wr(input int sel, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 5'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 0) begin m_loaded = 1'b1; m_en = d[9:8]; m_def = d[7:0]; end
        else if (sel == 1) m_top = d[AW-1:0];
        else if (sel >= 2 && sel <= 12) begin
            for (int j = 0; j < 8; j++) m_fix[(sel-2)*8 + j] = d[j*8 +: 8];
        end else if (sel >= 16) begin
            if (sel % 2 == 0) begin
                m_base[(sel-16)/2] = {d[AW-1:12], 12'h000};
                m_type[(sel-16)/2] = d[7:0];
            end else begin
                m_mask[(sel-16)/2] = {d[AW-1:12], 12'h000};
                m_on[(sel-16)/2]   = d[11];
            end
        end
    endtask

    task automatic fail_line(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_bad++;
        $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    endtask

    // lit >= 0 overrides the model with a hand-computed value.
    task automatic look(input logic [AW-1:0] s, input logic [AW-1:0] e, input string tag, input int lit);
        logic [7:0] exp;
        exp = (lit >= 0) ? 8'(lit) : ref_type(s, e);
        @(negedge clk);
        req_valid = 1'b1; req_start = s; req_end = e;
        @(negedge clk);
        req_valid = 1'b0;
        n_chk++;
        if (rsp_valid !== 1'b1 || rsp_type !== exp) begin
            n_bad++;
            $display("FAIL %s v=%0b actual=%02h expected=%02h", tag, rsp_valid, rsp_type, exp);
        end
    endtask

    task automatic set_rng(input int i, input logic [AW-1:0] b, input logic [7:0] t,
                           input logic [AW-1:0] m, input bit on);
        wr(16 + 2*i, {12'h000, b[AW-1:12], 4'h0, t});
        wr(17 + 2*i, {12'h000, m[AW-1:12], on, 11'h000});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] held;
        logic [AW-1:0] B;
        void'($urandom(32'd1234));
        for (int i = 0; i < 88; i++) m_fix[i] = 8'h00;
        for (int i = 0; i < NV; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_type[i] = 8'h00; m_on[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0 || rsp_type !== 8'hFF) fail_line("R2 reset", rsp_type, 8'hFF);

        // R1: nothing loaded yet.
        look(52'h2000_0000, 52'h2000_1000, "R1 unloaded", 8'hFF);

        for (int k = 0; k < 11; k++) wr(2 + k, {$urandom, $urandom});
        wr(0, 64'h305);
        // R3: the three granule bands and their edges.
        look(52'h0, 52'h1000, "R3 64k first", int'(m_fix[0]));
        look(52'h7FFFF, 52'h80000, "R3 64k last", int'(m_fix[7]));
        look(52'h80000, 52'h81000, "R3 16k first", int'(m_fix[8]));
        look(52'hBC000, 52'hBD000, "R3 16k last", int'(m_fix[23]));
        look(52'hC0000, 52'hC1000, "R3 4k first", int'(m_fix[24]));
        look(52'hFF000, 52'h100000, "R3 4k last", int'(m_fix[87]));

        B = 52'h1000_0000;
        set_rng(0, B, 8'h06, 52'hF_FFFF_FFF0_0000, 1'b1);
        set_rng(1, B, 8'h04, 52'hF_FFFF_FFE0_0000, 1'b1);
        set_rng(2, B, 8'h00, 52'hF_FFFF_FFF0_0000, 1'b0);
        look(B, B + 52'h1000, "R8 wb+wt and R5 disabled uc", 8'h04);
        // R2: idle cycle drops valid and holds type.
        held = rsp_type;
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0 || rsp_type !== held) fail_line("R2 idle", rsp_type, held);
        look(B, B + 52'h10_0000, "R11 exclusive end", 8'h04);
        look(B, B + 52'h10_0001, "R6 straddle", 8'hFE);
        set_rng(2, B, 8'h00, 52'hF_FFFF_FFF0_0000, 1'b1);
        look(B, B + 52'h1000, "R7 uc dominates", 8'h00);
        set_rng(2, B, 8'h01, 52'hF_FFFF_FFF0_0000, 1'b1);
        look(B, B + 52'h1000, "R7 disagree", 8'h00);
        set_rng(2, B, 8'h00, 52'hF_FFFF_FFF0_0000, 1'b1);
        set_rng(3, B, 8'h06, 52'hF_FFFF_FFFF_F000, 1'b1);
        look(B, B + 52'h2000, "R13 earlier uc wins", 8'h00);
        set_rng(2, B, 8'h00, 52'hF_FFFF_FFF0_0000, 1'b0);
        look(B, B + 52'h2000, "R13 later straddle", 8'hFE);
        look(52'h2000_0000, 52'h2000_1000, "R10 no match", 8'h05);
        wr(1, 64'h2_0000_0000);
        look(52'h1_0000_0000, 52'h1_0001_0000, "R9 boundary", 8'h06);
        look(52'h1_0000_0000, 52'h2_0000_0000, "R9 end at bound", 8'h06);
        look(52'h1_0000_0000, 52'h2_0000_0001, "R9 past bound", 8'h05);
        look(52'hFFFF_F000, 52'h1_0000_1000, "R9 below 4g", 8'h05);
        wr(0, 64'h107);
        look(B, B + 52'h1000, "R4 var off", 8'h07);
        look(52'h0, 52'h1000, "R3 fixed with var off", int'(m_fix[0]));
        wr(0, 64'h009);
        look(B, B + 52'h1000, "R1 disabled", 8'hFF);
        wr(0, 64'h30A);
        look(52'h3000_0000, 52'h3000_1000, "R12 next lookup sees write", 8'h0A);

        // Random phase: reconfigure now and then, aim requests near ranges.
        for (int it = 0; it < 400; it++) begin
            int r, sz;
            logic [AW-1:0] s, e, base, msk;
            if (it % 16 == 0) begin
                r = int'($urandom % NV);
                sz = 12 + int'($urandom % 16);
                base = {12'h0, $urandom, 8'h00} & ~((52'h1 << sz) - 1);
                msk = ~((52'h1 << sz) - 1);
                case ($urandom % 5)
                    0: set_rng(r, base, 8'h00, msk, ($urandom % 4) != 0);
                    1: set_rng(r, base, 8'h01, msk, ($urandom % 4) != 0);
                    2: set_rng(r, base, 8'h04, msk, ($urandom % 4) != 0);
                    3: set_rng(r, base, 8'h05, msk, ($urandom % 4) != 0);
                    default: set_rng(r, base, 8'h06, msk, ($urandom % 4) != 0);
                endcase
                if ($urandom % 8 == 0) wr(0, {54'h0, 2'($urandom), 8'($urandom)});
                else wr(0, {54'h0, 2'b11, 8'($urandom)});
                if ($urandom % 4 == 0) wr(1, {12'h0, $urandom, 20'h0});
            end
            r = int'($urandom % NV);
            case ($urandom % 4)
                0: s = 52'($urandom % 32'h100000);
                1: s = {12'h0, $urandom, 8'h00};
                default: s = m_base[r] + 52'($urandom % 32'h4000);
            endcase
            e = s + 52'(1 + ($urandom % 32'h8000));
            look(s, e, "R10 random mix", -1);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule